// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits in front of a small processor core and collects its interrupt requests. It takes three kinds of request. Active-low external pins, including a dedicated reset-interrupt pin and a nonmaskable pin, are synchronized and checked for a falling edge with a minimum low width. On-chip peripheral request lines are level inputs. A software request port carries its own vector number. Each recognized request is latched as a pending flag.

One winner is chosen by fixed priority: reset-interrupt, then NMI, then software, then hardware sources by ascending index. Hardware sources are maskable. They compete only when their bit in a software-written mask is 1 and the global enable is 1. Reset-interrupt, NMI and software requests ignore both. The winner is offered to the core as a request with a vector. The offer stays frozen until the core acknowledges it. The acknowledge clears the winner's pending flag, and for a maskable winner it also clears the global enable.

Top module: `irq_ctrl`

## Requirements
- R1: A high-to-low transition on an external, reset-interrupt or NMI pin that stays low across two consecutive rising clock edges sets that source's pending flag. If the pin falls just before edge k, pending is set at edge k+3 and irq_req_o rises at edge k+4 when the source is eligible and no request is outstanding.
- R2: A pin that is low across only one rising clock edge produces no request.
- R3: A pin held low produces exactly one request. A new request needs the pin to return high first.
- R4: A peripheral line that is high at a rising edge sets the pending flag of hardware source N_EXT+j, where j is the line index. External pin i is hardware source i.
- R5: Among pending eligible sources the winner is reset-interrupt, then NMI, then software, then hardware source 0, 1, 2 and so on upward.
- R6: Hardware source i can win only when mask bit i is 1 and the global enable is 1. gie_o shows the enable. mask_we_i loads the mask and gie_we_i loads the enable; both reset to 0.
- R7: Reset-interrupt, NMI and software requests win regardless of mask and global enable. A software request sets its pending flag at the edge where sw_req_i is high, and captures sw_vec_i.
- R8: The vector is 0 for reset-interrupt, 1 for NMI, the captured sw_vec_i for software, and 2+i for hardware source i.
- R9: While irq_req_o is high and irq_ack_i is low, irq_req_o and irq_vec_o hold, even when a higher-priority source becomes pending.
- R10: irq_ack_i high at an edge while irq_req_o is high clears the offered source's pending flag and lowers irq_req_o. If the offered source was a hardware source, the global enable also clears. Arbitration resumes at the next edge.
- R11: A new request for the acknowledged source arriving at the same edge as the acknowledge keeps its pending flag set. The source is offered again.
- R12: After reset irq_req_o is 0, irq_vec_o is 0 and gie_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_irq_ni | input | 1 | Reset-interrupt pin, active low, nonmaskable |
| nmi_ni | input | 1 | Nonmaskable interrupt pin, active low |
| ext_irq_ni | input | N_EXT | Maskable external pins, active low |
| periph_irq_i | input | N_INT | Peripheral request lines, active high |
| sw_req_i | input | 1 | Software interrupt request |
| sw_vec_i | input | VEC_W | Vector for the software request |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | N_EXT+N_INT | Mask write data, bit i enables hardware source i |
| gie_we_i | input | 1 | Global enable write strobe |
| gie_i | input | 1 | Global enable write data |
| irq_ack_i | input | 1 | Acknowledge from the core |
| irq_req_o | output | 1 | Request offered to the core |
| irq_vec_o | output | VEC_W | Vector of the offered request |
| gie_o | output | 1 | Current global enable |

## Verification
The bench builds the block with N_EXT=2, N_INT=3 and VEC_W=6. With these values every hardware vector (2 to 6) is distinct and easy to predict. External and peripheral sources can be made pending at the same edge, which tests the index ordering. A 6-bit software vector such as 42 cannot be confused with any fixed vector. The small counts keep the full priority chain from reset-interrupt down to the last peripheral line within a few short directed sequences.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_NMI = 2'd1,
    SRC_SW  = 2'd2,
    SRC_HW  = 2'd3
  } src_e;

  localparam int unsigned VEC_RST     = 0;
  localparam int unsigned VEC_NMI     = 1;
  localparam int unsigned VEC_HW_BASE = 2;
endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic fire_o
);
  logic sync1_q, sync2_q, hist1_q, hist2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      hist1_q <= 1'b1;
      hist2_q <= 1'b1;
    end else begin
      sync1_q <= pin_ni;
      sync2_q <= sync1_q;
      hist1_q <= sync2_q;
      hist2_q <= hist1_q;
    end
  end

  // high sample, then two lows in a row
  assign fire_o = hist2_q & ~hist1_q & ~sync2_q;

  a_r3_one_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N_HW  = 8,
  parameter int unsigned IDX_W = (N_HW > 1) ? $clog2(N_HW) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rst_pend_i,
  input  logic             nmi_pend_i,
  input  logic             sw_pend_i,
  input  logic [N_HW-1:0]  hw_pend_i,
  input  logic [N_HW-1:0]  mask_i,
  input  logic             gie_i,
  output logic             grant_o,
  output src_e             kind_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_HW-1:0] hw_elig;
  logic            hw_hit;

  always_comb begin
    hw_elig = hw_pend_i & mask_i & {N_HW{gie_i}};
    hw_hit  = 1'b0;
    idx_o   = '0;
    for (int i = N_HW - 1; i >= 0; i--) begin
      if (hw_elig[i]) begin
        hw_hit = 1'b1;
        idx_o  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    kind_o  = SRC_HW;
    grant_o = 1'b0;
    if (rst_pend_i) begin
      kind_o  = SRC_RST;
      grant_o = en_i;
    end else if (nmi_pend_i) begin
      kind_o  = SRC_NMI;
      grant_o = en_i;
    end else if (sw_pend_i) begin
      kind_o  = SRC_SW;
      grant_o = en_i;
    end else if (hw_hit) begin
      kind_o  = SRC_HW;
      grant_o = en_i;
    end
  end

  // R6: a maskable grant needs a pending, unmasked source and global enable
  a_r6_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && kind_o == SRC_HW) |-> (gie_i && mask_i[idx_o] && hw_pend_i[idx_o]));

  // R5: no hardware grant while a nonmaskable source is pending
  a_r5_nm_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && (rst_pend_i || nmi_pend_i || sw_pend_i)) |-> kind_o != SRC_HW);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned N_INT = 4,
  parameter int unsigned VEC_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rst_irq_ni,
  input  logic                   nmi_ni,
  input  logic [N_EXT-1:0]       ext_irq_ni,
  input  logic [N_INT-1:0]       periph_irq_i,
  input  logic                   sw_req_i,
  input  logic [VEC_W-1:0]       sw_vec_i,
  input  logic                   mask_we_i,
  input  logic [N_EXT+N_INT-1:0] mask_i,
  input  logic                   gie_we_i,
  input  logic                   gie_i,
  input  logic                   irq_ack_i,
  output logic                   irq_req_o,
  output logic [VEC_W-1:0]       irq_vec_o,
  output logic                   gie_o
);
  localparam int unsigned N_HW   = N_EXT + N_INT;
  localparam int unsigned IDX_W  = (N_HW > 1) ? $clog2(N_HW) : 1;
  localparam int unsigned N_PINS = N_EXT + 2;
  localparam int unsigned P_RST  = N_EXT;
  localparam int unsigned P_NMI  = N_EXT + 1;

  logic [N_PINS-1:0] pins_n, fire;
  assign pins_n = {nmi_ni, rst_irq_ni, ext_irq_ni};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    irq_fall_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (pins_n[p]),
      .fire_o (fire[p])
    );
  end

  logic [N_HW-1:0]  hw_pend_q, mask_q, hw_set, hw_clr;
  logic             rst_pend_q, nmi_pend_q, sw_pend_q, gie_q;
  logic [VEC_W-1:0] sw_vec_q, vec_q, vec_d;
  logic             req_q, take;
  src_e             sel_kind_q, win_kind;
  logic [IDX_W-1:0] sel_idx_q, win_idx;
  logic             grant;

  assign hw_set = {periph_irq_i, fire[N_EXT-1:0]};
  assign take   = req_q & irq_ack_i;
  assign hw_clr = (take && sel_kind_q == SRC_HW) ? (N_HW'(1) << sel_idx_q) : '0;

  logic clr_rst, clr_nmi, clr_sw;
  assign clr_rst = take && sel_kind_q == SRC_RST;
  assign clr_nmi = take && sel_kind_q == SRC_NMI;
  assign clr_sw  = take && sel_kind_q == SRC_SW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_pend_q  <= '0;
      rst_pend_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      hw_pend_q  <= (hw_pend_q & ~hw_clr) | hw_set;
      rst_pend_q <= (rst_pend_q & ~clr_rst) | fire[P_RST];
      nmi_pend_q <= (nmi_pend_q & ~clr_nmi) | fire[P_NMI];
    end
  end

  // software pending: a new request is taken when free or being cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_pend_q <= 1'b0;
      sw_vec_q  <= '0;
    end else if (sw_req_i && (!sw_pend_q || clr_sw)) begin
      sw_pend_q <= 1'b1;
      sw_vec_q  <= sw_vec_i;
    end else if (clr_sw) begin
      sw_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      if (take && sel_kind_q == SRC_HW) gie_q <= 1'b0;
      else if (gie_we_i)                gie_q <= gie_i;
    end
  end

  irq_arbiter #(.N_HW(N_HW), .IDX_W(IDX_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (!req_q),
    .rst_pend_i (rst_pend_q),
    .nmi_pend_i (nmi_pend_q),
    .sw_pend_i  (sw_pend_q),
    .hw_pend_i  (hw_pend_q),
    .mask_i     (mask_q),
    .gie_i      (gie_q),
    .grant_o    (grant),
    .kind_o     (win_kind),
    .idx_o      (win_idx)
  );

  always_comb begin
    unique case (win_kind)
      SRC_RST: vec_d = VEC_W'(VEC_RST);
      SRC_NMI: vec_d = VEC_W'(VEC_NMI);
      SRC_SW:  vec_d = sw_vec_q;
      default: vec_d = VEC_W'(VEC_HW_BASE) + VEC_W'(win_idx);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      vec_q      <= '0;
      sel_kind_q <= SRC_RST;
      sel_idx_q  <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && grant) begin
      req_q      <= 1'b1;
      vec_q      <= vec_d;
      sel_kind_q <= win_kind;
      sel_idx_q  <= win_idx;
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;
  assign gie_o     = gie_q;

  a_r9_hold_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !irq_ack_i) |=> (irq_req_o && $stable(irq_vec_o)));

  a_r10_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i) |=> !irq_req_o);

  a_r10_gie_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && irq_ack_i && sel_kind_q == SRC_HW) |=> !gie_o);

  a_r6_gie_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_req_o) && sel_kind_q == SRC_HW) |-> $past(gie_q));
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_EXT = 2;
  localparam int N_INT = 3;
  localparam int VEC_W = 6;
  localparam int N_HW  = N_EXT + N_INT;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_irq_ni = 1'b1, nmi_ni = 1'b1;
  logic [N_EXT-1:0] ext_irq_ni = '1;
  logic [N_INT-1:0] periph_irq_i = '0;
  logic sw_req_i = 1'b0;
  logic [VEC_W-1:0] sw_vec_i = '0;
  logic mask_we_i = 1'b0;
  logic [N_HW-1:0] mask_i = '0;
  logic gie_we_i = 1'b0, gie_i = 1'b0, irq_ack_i = 1'b0;
  logic irq_req_o, gie_o;
  logic [VEC_W-1:0] irq_vec_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl #(.N_EXT(N_EXT), .N_INT(N_INT), .VEC_W(VEC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_irq_ni(rst_irq_ni), .nmi_ni(nmi_ni),
    .ext_irq_ni(ext_irq_ni), .periph_irq_i(periph_irq_i), .sw_req_i(sw_req_i),
    .sw_vec_i(sw_vec_i), .mask_we_i(mask_we_i), .mask_i(mask_i),
    .gie_we_i(gie_we_i), .gie_i(gie_i), .irq_ack_i(irq_ack_i),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .gie_o(gie_o)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_gie(logic v);
    gie_we_i = 1'b1; gie_i = v; cyc(1); gie_we_i = 1'b0;
  endtask

  task automatic set_mask(logic [N_HW-1:0] m);
    mask_we_i = 1'b1; mask_i = m; cyc(1); mask_we_i = 1'b0;
  endtask

  task automatic ack();
    irq_ack_i = 1'b1; cyc(1); irq_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 req", irq_req_o, 0);
    chk("R12 vec", irq_vec_o, 0);
    chk("R12 gie", gie_o, 0);
  endtask

  task automatic t_edge_latency();
    set_mask('1); set_gie(1'b1);
    ext_irq_ni[0] = 1'b0;
    cyc(4); chk("R1 req before k+4", irq_req_o, 0);
    cyc(1); chk("R1 req at k+4", irq_req_o, 1);
    chk("R8 vec ext0", irq_vec_o, 2);
    ack();
    chk("R10 req dropped", irq_req_o, 0);
    chk("R10 gie cleared", gie_o, 0);
    ext_irq_ni[0] = 1'b1; cyc(4);
  endtask

  task automatic t_short_pulse();
    set_gie(1'b1);
    ext_irq_ni[1] = 1'b0; cyc(1); ext_irq_ni[1] = 1'b1;
    cyc(8); chk("R2 short pulse ignored", irq_req_o, 0);
  endtask

  task automatic t_held_low();
    ext_irq_ni[1] = 1'b0;
    cyc(5); chk("R3 first req", irq_req_o, 1);
    chk("R8 vec ext1", irq_vec_o, 3);
    ack(); set_gie(1'b1);
    cyc(8); chk("R3 no refire while low", irq_req_o, 0);
    ext_irq_ni[1] = 1'b1; cyc(4);
    set_gie(1'b0);
  endtask

  task automatic t_mask();
    set_mask(5'b00000); set_gie(1'b1);
    periph_irq_i[0] = 1'b1; cyc(1); periph_irq_i[0] = 1'b0;
    cyc(5); chk("R6 masked source blocked", irq_req_o, 0);
    set_gie(1'b0); set_mask('1);
    cyc(3); chk("R6 gie low blocks", irq_req_o, 0);
    set_gie(1'b1);
    cyc(1); chk("R4 periph0 req", irq_req_o, 1);
    chk("R4 vec periph0", irq_vec_o, 4);
    ack();
  endtask

  task automatic t_hw_priority();
    periph_irq_i = 3'b110; cyc(1); periph_irq_i = '0;
    set_gie(1'b1);
    cyc(1); chk("R5 lower index first", irq_vec_o, 5);
    ack(); chk("R10 gie cleared again", gie_o, 0);
    set_gie(1'b1);
    cyc(1); chk("R5 next index", irq_vec_o, 6);
    ack();
  endtask

  task automatic t_nonmask();
    set_mask('0);
    sw_vec_i = 6'd42; sw_req_i = 1'b1; cyc(1); sw_req_i = 1'b0;
    cyc(1); chk("R7 sw req", irq_req_o, 1);
    chk("R8 sw vec", irq_vec_o, 42);
    ack();
    nmi_ni = 1'b0; cyc(5);
    chk("R7 nmi req", irq_req_o, 1);
    chk("R8 nmi vec", irq_vec_o, 1);
    ack(); nmi_ni = 1'b1;
    rst_irq_ni = 1'b0; cyc(5);
    chk("R7 rst req", irq_req_o, 1);
    chk("R8 rst vec", irq_vec_o, 0);
    ack(); rst_irq_ni = 1'b1; cyc(4);
  endtask

  task automatic t_full_order();
    set_mask('1); set_gie(1'b1);
    rst_irq_ni = 1'b0; nmi_ni = 1'b0;
    cyc(3);
    sw_vec_i = 6'd33; sw_req_i = 1'b1;
    periph_irq_i[0] = 1'b1;
    cyc(1); sw_req_i = 1'b0; periph_irq_i[0] = 1'b0;
    cyc(1); chk("R5 rst wins", irq_vec_o, 0);
    ack(); cyc(1); chk("R5 nmi second", irq_vec_o, 1);
    ack(); cyc(1); chk("R5 sw third", irq_vec_o, 33);
    ack(); cyc(1); chk("R5 hw last", irq_vec_o, 4);
    ack();
    rst_irq_ni = 1'b1; nmi_ni = 1'b1; cyc(4);
  endtask

  task automatic t_hold();
    set_gie(1'b1);
    periph_irq_i[2] = 1'b1; cyc(1); periph_irq_i[2] = 1'b0;
    cyc(1); chk("R9 hw offered", irq_vec_o, 6);
    nmi_ni = 1'b0; cyc(8);
    chk("R9 req held", irq_req_o, 1);
    chk("R9 vec held", irq_vec_o, 6);
    ack(); cyc(1); chk("R9 nmi after ack", irq_vec_o, 1);
    ack(); nmi_ni = 1'b1; cyc(4);
  endtask

  task automatic t_reack();
    nmi_ni = 1'b0; cyc(5);
    chk("R11 nmi first", irq_vec_o, 1);
    nmi_ni = 1'b1; cyc(4);
    nmi_ni = 1'b0; cyc(3);
    irq_ack_i = 1'b1; cyc(1); irq_ack_i = 1'b0;
    chk("R11 req dropped on ack", irq_req_o, 0);
    cyc(1); chk("R11 req again", irq_req_o, 1);
    chk("R11 vec again", irq_vec_o, 1);
    ack(); nmi_ni = 1'b1;
    cyc(2); chk("R11 cleared after second ack", irq_req_o, 0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_edge_latency();
    t_short_pulse();
    t_held_low();
    t_mask();
    t_hw_priority();
    t_nonmask();
    t_full_order();
    t_hold();
    t_reack();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule